// File: doc/BRIEF.md
# Big-endian load/store lane aligner

This block sits between a word-wide data memory and the register file of a processor that addresses memory in bytes. On the load side it takes the word read from memory, the two low address bits and an access kind. It selects the addressed byte, halfword or word and widens it to a full register value. A byte or halfword is widened either by copying its top bit into the upper bits or by filling the upper bits with zeros.

On the store side it takes the register value, the two low address bits and an access size. It returns a write-data word with the item placed in the right lanes and a per-lane write-enable mask. Lanes are numbered in big-endian order, so the byte at the lowest address is the most significant byte of the word.

Both paths flag accesses that are not aligned to their own size. Both paths are registered once, so each result appears one clock after its request. The loads and stores are independent and may be requested in the same cycle.

Top module: `lsa_aligner`

## Requirements
- R1: While `rst_n` is low, every output is zero after the next rising clock edge.
- R2: `ld_done` is high in the cycle after a cycle with `ld_valid` high, and low otherwise. `st_done` follows `st_valid` in the same way. Results appear together with their done flag.
- R3: The access kind is 3 bits. Bit 2 set means unsigned. Bits 1:0 give the size: 00 byte, 01 halfword, 10 word, 11 illegal. A byte load at offset k returns word bits [31-8k : 24-8k], so offset 0 returns bits 31:24 and offset 3 returns bits 7:0.
- R4: A halfword load at offset 0 returns bits 31:16, and at offset 2 returns bits 15:0.
- R5: Signed byte loads (kind 000) and signed halfword loads (kind 001) copy the item's top bit into every bit above it, up to bit 31.
- R6: Unsigned byte loads (kind 100) and unsigned halfword loads (kind 101) fill every bit above the item with zeros.
- R7: A word load (kind 010 or 110) at offset 0 returns the read word unchanged.
- R8: A load is misaligned in three cases: a halfword with offset bit 0 set, a word with a nonzero offset, or size code 11. A misaligned load raises `ld_misalign` and returns zero.
- R9: A byte store (size 00) at offset k sets only `st_byte_en[3-k]`. Enable bit i covers `st_wdata[8i+7:8i]`. The low 8 bits of the register value are copied into all four lanes.
- R10: A halfword store (size 01) enables 4'b1100 at offset 0 and 4'b0011 at offset 2. The low 16 bits of the register value are copied into both halves.
- R11: A word store (size 10) at offset 0 enables 4'b1111 and writes the register value unchanged.
- R12: A store is misaligned in three cases: a halfword with offset bit 0 set, a word with a nonzero offset, or size code 11. A misaligned store raises `st_misalign` and drives `st_byte_en` to 4'b0000.
- R13: In the cycle after a cycle with `st_valid` low, `st_byte_en` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load request this cycle |
| ld_word | input | 32 | Word read from memory |
| ld_offset | input | 2 | Low address bits of the load |
| ld_kind | input | 3 | Load kind: bit 2 unsigned, bits 1:0 size |
| st_valid | input | 1 | Store request this cycle |
| st_data | input | 32 | Register value to store |
| st_offset | input | 2 | Low address bits of the store |
| st_size | input | 2 | Store size: 00 byte, 01 halfword, 10 word, 11 illegal |
| ld_result | output | 32 | Extended register value |
| ld_misalign | output | 1 | Load alignment error |
| ld_done | output | 1 | Load result valid |
| st_wdata | output | 32 | Lane-positioned write data |
| st_byte_en | output | 4 | Per-lane write enable, bit 3 is bits 31:24 |
| st_misalign | output | 1 | Store alignment error |
| st_done | output | 1 | Store result valid |

## Verification
Every load and store result is due exactly one rising edge after the cycle in which its request was presented. The bench drives each request on a falling edge and records the value it expects for that request. On the following falling edge, once the done flag is high, it compares the registered outputs against the oldest recorded value. An idle store cycle is checked the same way, one edge later, by requiring a zero enable mask.

// File: rtl/lsa_pkg.sv
// Shared types for the load/store lane aligner.
// Assumes: a kind code keeps the unsigned flag in its top bit.
package lsa_pkg;

    // Access size codes, shared by loads and stores.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } lsa_size_e;

    // Load kind: unsigned flag plus size.
    typedef struct packed {
        logic      uns;
        lsa_size_e size;
    } lsa_kind_t;

endpackage

// File: rtl/lsa_align_check.sv
// Alignment checker: reports whether an access of the given size at the
// given byte offset crosses its natural boundary or uses the illegal size.
// Assumes: a halfword is two lanes and a word covers all LANES lanes.
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lsa_size_e        size,
    input  logic [OFF_W-1:0] offset,
    output logic             misalign
);

    // Decide alignment by size class.
    always_comb begin
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = offset[0];
            SZ_WORD: misalign = (offset != '0);
            default: misalign = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Load path: picks the addressed byte or halfword of a big-endian word
// and widens it with sign or zero fill; a whole word passes through.
// Assumes: misaligned or illegal accesses return zero.
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = BYTE_W * LANES,
    localparam int HALF_W = 2 * BYTE_W,
    localparam int HALVES = LANES / 2,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  offset,
    input  lsa_kind_t         kind,
    input  logic              misalign,
    output logic [DATA_W-1:0] value
);

    logic [BYTE_W-1:0] lane_byte [LANES];
    logic [HALF_W-1:0] lane_half [HALVES];
    logic [BYTE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic              byte_fill;
    logic              half_fill;

    // Byte k in address order lives at the top of the word for k = 0.
    for (genvar k = 0; k < LANES; k++) begin : g_byte_lane
        assign lane_byte[k] = word[DATA_W-1-k*BYTE_W -: BYTE_W];
    end

    // Halfword h in address order, same big-endian rule.
    for (genvar h = 0; h < HALVES; h++) begin : g_half_lane
        assign lane_half[h] = word[DATA_W-1-h*HALF_W -: HALF_W];
    end

    // Select the addressed items.
    always_comb begin
        sel_byte = lane_byte[offset];
        sel_half = lane_half[offset[OFF_W-1:1]];
    end

    // Fill bit for the upper part: the item's top bit unless unsigned.
    always_comb begin
        byte_fill = sel_byte[BYTE_W-1] & ~kind.uns;
        half_fill = sel_half[HALF_W-1] & ~kind.uns;
    end

    // Widen by size; misaligned accesses yield zero.
    always_comb begin
        if (misalign) begin
            value = '0;
        end else begin
            unique case (kind.size)
                SZ_BYTE: value = {{(DATA_W-BYTE_W){byte_fill}}, sel_byte};
                SZ_HALF: value = {{(DATA_W-HALF_W){half_fill}}, sel_half};
                SZ_WORD: value = word;
                default: value = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsa_store_place.sv
// Store path: copies the low item of the register value into every lane
// it may land in and builds the big-endian lane enable mask.
// Assumes: enable bit i covers data bits [BYTE_W*i +: BYTE_W].
module lsa_store_place
    import lsa_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = BYTE_W * LANES,
    localparam int HALF_W = 2 * BYTE_W,
    localparam int HALVES = LANES / 2,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [OFF_W-1:0]  offset,
    input  lsa_size_e         size,
    input  logic              misalign,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  byte_en
);

    // Replicate the item; the enable mask picks the live lanes.
    always_comb begin
        unique case (size)
            SZ_BYTE: wdata = {LANES{data[BYTE_W-1:0]}};
            SZ_HALF: wdata = {HALVES{data[HALF_W-1:0]}};
            default: wdata = data;
        endcase
    end

    // Per lane k in address order, decide whether it is written.
    for (genvar k = 0; k < LANES; k++) begin : g_lane_en
        logic hit;
        // Does lane k belong to the addressed item?
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (offset == OFF_W'(k));
                SZ_HALF: hit = (offset[OFF_W-1:1] == (OFF_W-1)'(k / 2));
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
        assign byte_en[LANES-1-k] = hit & ~misalign;
    end

endmodule

// File: rtl/lsa_aligner.sv
// Top of the load/store lane aligner: checks alignment on both paths,
// extracts and widens loads, places stores, and registers all results
// once so each appears one cycle after its request.
// Assumes: synchronous active-low reset; load and store are independent.
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = BYTE_W * LANES,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_word,
    input  logic [OFF_W-1:0]  ld_offset,
    input  logic [2:0]        ld_kind,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_data,
    input  logic [OFF_W-1:0]  st_offset,
    input  logic [1:0]        st_size,
    output logic [DATA_W-1:0] ld_result,
    output logic              ld_misalign,
    output logic              ld_done,
    output logic [DATA_W-1:0] st_wdata,
    output logic [LANES-1:0]  st_byte_en,
    output logic              st_misalign,
    output logic              st_done
);

    lsa_kind_t         ld_kind_s;
    lsa_size_e         st_size_s;
    logic              ld_mis_c;
    logic              st_mis_c;
    logic [DATA_W-1:0] ld_value_c;
    logic [DATA_W-1:0] st_wdata_c;
    logic [LANES-1:0]  st_en_c;

    // Give the raw codes their typed views.
    always_comb begin
        ld_kind_s = lsa_kind_t'(ld_kind);
        st_size_s = lsa_size_e'(st_size);
    end

    lsa_align_check #(.LANES(LANES)) u_ld_align (
        .size     (ld_kind_s.size),
        .offset   (ld_offset),
        .misalign (ld_mis_c)
    );

    lsa_align_check #(.LANES(LANES)) u_st_align (
        .size     (st_size_s),
        .offset   (st_offset),
        .misalign (st_mis_c)
    );

    lsa_load_extract #(.BYTE_W(BYTE_W), .LANES(LANES)) u_load (
        .word     (ld_word),
        .offset   (ld_offset),
        .kind     (ld_kind_s),
        .misalign (ld_mis_c),
        .value    (ld_value_c)
    );

    lsa_store_place #(.BYTE_W(BYTE_W), .LANES(LANES)) u_store (
        .data     (st_data),
        .offset   (st_offset),
        .size     (st_size_s),
        .misalign (st_mis_c),
        .wdata    (st_wdata_c),
        .byte_en  (st_en_c)
    );

    // Load result register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_done     <= 1'b0;
            ld_result   <= '0;
            ld_misalign <= 1'b0;
        end else begin
            ld_done <= ld_valid;
            if (ld_valid) begin
                ld_result   <= ld_value_c;
                ld_misalign <= ld_mis_c;
            end
        end
    end

    // Store result register: enables drop to zero on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done     <= 1'b0;
            st_wdata    <= '0;
            st_byte_en  <= '0;
            st_misalign <= 1'b0;
        end else begin
            st_done    <= st_valid;
            st_byte_en <= st_valid ? st_en_c : '0;
            if (st_valid) begin
                st_wdata    <= st_wdata_c;
                st_misalign <= st_mis_c;
            end
        end
    end

endmodule

// File: rtl/lsa_aligner_chk.sv
// Checker for the load/store lane aligner, bound to the top module.
module lsa_aligner_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [2:0]        ld_kind,
    input logic              st_valid,
    input logic [DATA_W-1:0] ld_result,
    input logic              ld_misalign,
    input logic              ld_done,
    input logic [LANES-1:0]  st_byte_en,
    input logic              st_misalign,
    input logic              st_done
);

    // R2
    ld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_done);

    // R2
    st_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> st_done);

    // R5
    ld_sign_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'b000) |=>
        (ld_misalign || ld_result[DATA_W-1:BYTE_W] ==
                        {(DATA_W-BYTE_W){ld_result[BYTE_W-1]}}));

    // R6
    ld_zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'b100) |=>
        (ld_result[DATA_W-1:BYTE_W] == '0));

    // R8
    ld_mis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && ld_misalign) |-> (ld_result == '0));

    // R9
    st_en_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> ($countones(st_byte_en) inside {0, 1, 2, LANES}));

    // R12
    st_mis_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && st_misalign) |-> (st_byte_en == '0));

    // R13
    st_idle_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> (st_byte_en == '0));

endmodule

bind lsa_aligner lsa_aligner_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_kind     (ld_kind),
    .st_valid    (st_valid),
    .ld_result   (ld_result),
    .ld_misalign (ld_misalign),
    .ld_done     (ld_done),
    .st_byte_en  (st_byte_en),
    .st_misalign (st_misalign),
    .st_done     (st_done)
);

// File: tb/lsa_aligner_tb.sv
module lsa_aligner_tb;

    typedef struct {
        logic [31:0] res;
        logic        mis;
        logic [2:0]  kind;
        logic [1:0]  off;
    } ld_item_t;

    typedef struct {
        logic [31:0] wd;
        logic [3:0]  en;
        logic        mis;
        logic [1:0]  size;
        logic [1:0]  off;
    } st_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_word = '0;
    logic [1:0]  ld_offset = '0;
    logic [2:0]  ld_kind = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_data = '0;
    logic [1:0]  st_offset = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] ld_result;
    logic        ld_misalign;
    logic        ld_done;
    logic [31:0] st_wdata;
    logic [3:0]  st_byte_en;
    logic        st_misalign;
    logic        st_done;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    ld_item_t ld_q[$];
    st_item_t st_q[$];

    always #2.5 clk = ~clk;

    lsa_aligner u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_word(ld_word), .ld_offset(ld_offset), .ld_kind(ld_kind),
        .st_valid(st_valid), .st_data(st_data), .st_offset(st_offset), .st_size(st_size),
        .ld_result(ld_result), .ld_misalign(ld_misalign), .ld_done(ld_done),
        .st_wdata(st_wdata), .st_byte_en(st_byte_en), .st_misalign(st_misalign),
        .st_done(st_done)
    );

    // Expected load result, from R3..R8.
    function automatic ld_item_t model_ld(logic [31:0] w, logic [1:0] off, logic [2:0] kind);
        ld_item_t it;
        logic [31:0] sh;
        it.kind = kind;
        it.off  = off;
        it.res  = '0;
        case (kind[1:0])
            2'b00: begin
                it.mis = 1'b0;
                sh = w >> (8 * (3 - int'(off)));
                it.res = kind[2] ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
            end
            2'b01: begin
                it.mis = off[0];
                sh = off[1] ? w : (w >> 16);
                if (!it.mis)
                    it.res = kind[2] ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
            end
            2'b10: begin
                it.mis = (off != 2'b00);
                if (!it.mis) it.res = w;
            end
            default: it.mis = 1'b1;
        endcase
        return it;
    endfunction

    // Expected store result, from R9..R12.
    function automatic st_item_t model_st(logic [31:0] d, logic [1:0] off, logic [1:0] size);
        st_item_t it;
        it.size = size;
        it.off  = off;
        it.wd   = d;
        it.en   = 4'b0000;
        case (size)
            2'b00: begin it.mis = 1'b0; it.en = 4'b1000 >> off; it.wd = {4{d[7:0]}}; end
            2'b01: begin
                it.mis = off[0];
                it.wd  = {2{d[15:0]}};
                if (!it.mis) it.en = off[1] ? 4'b0011 : 4'b1100;
            end
            2'b10: begin it.mis = (off != 2'b00); if (!it.mis) it.en = 4'b1111; end
            default: it.mis = 1'b1;
        endcase
        return it;
    endfunction

    function automatic string ld_req(logic [2:0] kind, logic mis);
        if (mis) return "R8";
        if (kind[1:0] == 2'b10) return "R7";
        if (kind[2]) return "R6";
        return (kind[1:0] == 2'b00) ? "R3/R5" : "R4/R5";
    endfunction

    function automatic string st_req(logic [1:0] size, logic mis);
        if (mis) return "R12";
        if (size == 2'b00) return "R9";
        if (size == 2'b01) return "R10";
        return "R11";
    endfunction

    // Driver: one load and/or store request for one cycle.
    task automatic drive(bit do_ld, logic [31:0] w, logic [1:0] lo, logic [2:0] k,
                         bit do_st, logic [31:0] d, logic [1:0] so, logic [1:0] sz);
        @(negedge clk);
        ld_valid = do_ld; ld_word = w; ld_offset = lo; ld_kind = k;
        st_valid = do_st; st_data = d; st_offset = so; st_size = sz;
        if (do_ld) ld_q.push_back(model_ld(w, lo, k));
        if (do_st) st_q.push_back(model_st(d, so, sz));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: results are due on the falling edge after the capturing edge.
    always @(negedge clk) begin
        if (running) begin
            if (ld_done) begin
                if (ld_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected ld_done", 32'd1, 32'd0);
                end else begin
                    ld_item_t e;
                    e = ld_q.pop_front();
                    check(ld_misalign == e.mis, ld_req(e.kind, e.mis), "ld_misalign",
                          {31'd0, ld_misalign}, {31'd0, e.mis});
                    check(ld_result == e.res, ld_req(e.kind, e.mis), "ld_result",
                          ld_result, e.res);
                end
            end
            if (st_done) begin
                if (st_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected st_done", 32'd1, 32'd0);
                end else begin
                    st_item_t e;
                    e = st_q.pop_front();
                    check(st_misalign == e.mis, st_req(e.size, e.mis), "st_misalign",
                          {31'd0, st_misalign}, {31'd0, e.mis});
                    check(st_byte_en == e.en, st_req(e.size, e.mis), "st_byte_en",
                          {28'd0, st_byte_en}, {28'd0, e.en});
                    if (!e.mis)
                        check(st_wdata == e.wd, st_req(e.size, e.mis), "st_wdata",
                              st_wdata, e.wd);
                end
            end else begin
                // R13: idle store cycle writes nothing
                check(st_byte_en == 4'b0000, "R13", "idle st_byte_en",
                      {28'd0, st_byte_en}, 32'd0);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 32'd0, 32'd1);
        summary();
    end

    initial begin
        // R1: reset state, with inputs active during reset
        ld_valid = 1'b1; st_valid = 1'b1; ld_word = 32'hFFFF_FFFF; st_size = 2'b10;
        repeat (3) @(negedge clk);
        check(ld_result == '0 && !ld_misalign && !ld_done, "R1", "load outputs in reset",
              ld_result, 32'd0);
        check(st_wdata == '0 && st_byte_en == '0 && !st_misalign && !st_done, "R1",
              "store outputs in reset", st_wdata, 32'd0);
        ld_valid = 1'b0; st_valid = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;
        idle(2);

        // R3..R8 and R9..R12: every kind/size at every offset, two data patterns
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 8; k++) begin
                for (int o = 0; o < 4; o++) begin
                    drive(1'b1, p ? 32'h7F01_80FF : 32'h8A3C_F15E, 2'(o), 3'(k),
                          1'b1, p ? 32'hCAFE_8B07 : 32'h1234_56A9, 2'(o), 2'(k));
                end
            end
        end
        idle(1);

        // R2: sparse loads and stores separated by idle cycles
        drive(1'b1, 32'hF00D_0080, 2'd3, 3'b000, 1'b0, '0, '0, '0);
        idle(2);
        drive(1'b0, '0, '0, '0, 1'b1, 32'h0000_00EE, 2'd1, 2'b00);
        idle(1);
        drive(1'b1, 32'h8000_1234, 2'd0, 3'b101, 1'b1, 32'hABCD_EF01, 2'd2, 2'b01);
        idle(3);

        // R8/R12: misaligned back to back
        drive(1'b1, 32'h1111_2222, 2'd1, 3'b001, 1'b1, 32'h3333_4444, 2'd3, 2'b01);
        drive(1'b1, 32'h1111_2222, 2'd2, 3'b110, 1'b1, 32'h3333_4444, 2'd1, 2'b10);
        drive(1'b1, 32'h1111_2222, 2'd0, 3'b011, 1'b1, 32'h3333_4444, 2'd0, 2'b11);
        idle(3);

        check(ld_q.size() == 0 && st_q.size() == 0, "R2", "pending results",
              32'(ld_q.size() + st_q.size()), 32'd0);
        running = 1'b0;
        summary();
    end

endmodule